// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block lets clocked logic read and write an external asynchronous static memory organised as 128K words of 8 bits. A requester offers one word at a time over a valid/ready handshake, with a read/write flag, a 17-bit address and write data. The controller runs the memory pins for that request: the address, a low-true and a high-true chip enable, a low-true write strobe, a low-true output enable, and a shared 8-bit data bus that it drives only while it writes.

The memory's timing minima are given to the block as nanosecond parameters, together with the clock period. The block rounds each of them up to a whole number of cycles, and never to fewer than one. All memory controls come from registers, so they change only on clock edges.

The memory stores a word on the rising edge of the write strobe. The block therefore keeps the address, the data and both enables steady for one cycle after that edge. When a write follows a read, the block waits for the memory to release the bus before it turns its own data drivers on. Read data is captured at the end of the access wait and returned with a one-cycle strobe.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, and whenever no request is in progress, mem_ce_n is 1, mem_ce is 0, mem_we_n is 1, mem_oe_n is 1, mem_dq_oe is 0, req_ready is 1 and rd_valid is 0.
- R2: A read (req_we=0) drives mem_ce_n=0, mem_ce=1, mem_we_n=1 and mem_oe_n=0. It captures mem_dq at the end of the access wait and shows that word on rd_data while rd_valid is high for exactly one cycle.
- R3: In a write (req_we=1), the controller drives the address and the data bus (mem_dq_oe=1) for at least the setup count of cycles before mem_we_n falls.
- R4: In the cycle after mem_we_n rises, the address, the driven data and both enables are still unchanged.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0. When a write follows a read, the controller waits the release count of cycles with mem_oe_n=1 and the bus undriven before it sets mem_dq_oe, so the two sides never drive mem_dq together.
- R6: req_ready falls in the cycle after a request is accepted and stays low until that request has fully completed.
- R7: Each cycle count is the ceiling of its nanosecond minimum divided by CLK_PERIOD_NS, and at least 1. rd_valid rises exactly ACC cycles after acceptance. mem_we_n stays low for exactly WP cycles, where WP is the largest of the pulse count, the address-to-write-end count less the setup count, and the data-to-write-end count less the setup count.
- R8: A read returns the word most recently written to the same address, including the lowest and highest addresses.
- R9: mem_oe_n is 1 whenever mem_we_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | DATA_W | Returned read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Low-true chip enable |
| mem_ce | output | 1 | High-true chip enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_dq_oe | output | 1 | Controller drives mem_dq |
| mem_dq | inout | DATA_W | Shared memory data bus |

## Verification
The bench builds the block with its default values:
- a 5 ns clock;
- a 10 ns access time, giving a two-cycle read wait;
- a 7 ns write pulse, giving two cycles;
- a 1 ns setup, giving one cycle;
- a 5 ns bus release, giving one cycle.

With counts this small, a wait that is one cycle short or long shows up as a wrong read word or a wrong strobe length, rather than being hidden by slack. The memory model drives a corrupted word until the access wait has passed, and keeps driving for one cycle after output enable rises. This makes an early capture, a missing turnaround, or a bus fight visible. Addresses 0 and 1FFFF are covered, along with overwrites and both read/write orderings.

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl #(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 5,
  parameter int T_ACCESS_NS    = 10,
  parameter int T_WPULSE_NS    = 7,
  parameter int T_ADDR_WEND_NS = 8,
  parameter int T_DATA_WEND_NS = 5,
  parameter int T_SETUP_NS     = 1,
  parameter int T_RELEASE_NS   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  inout  wire  [DATA_W-1:0] mem_dq
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC_CYC = to_cyc(T_ACCESS_NS);
  localparam int SU_CYC  = to_cyc(T_SETUP_NS);
  localparam int WP_CYC  = max2(to_cyc(T_WPULSE_NS),
                           max2(to_cyc(T_ADDR_WEND_NS) - SU_CYC,
                                to_cyc(T_DATA_WEND_NS) - SU_CYC));
  localparam int TA_CYC  = to_cyc(T_RELEASE_NS);
  localparam int MAX_CYC = max2(max2(ACC_CYC, SU_CYC), max2(WP_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_TURN, S_WSETUP, S_WPULSE, S_WHOLD
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic              after_rd;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (st == S_IDLE);
  assign mem_dq    = mem_dq_oe ? wdata_q : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      after_rd  <= 1'b0;
      wdata_q   <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          mem_ce   <= 1'b1;
          if (!req_we) begin
            mem_oe_n <= 1'b0;
            after_rd <= 1'b1;
            cnt      <= CNT_W'(ACC_CYC - 1);
            st       <= S_READ;
          end else begin
            wdata_q  <= req_wdata;
            after_rd <= 1'b0;
            if (after_rd) begin
              cnt <= CNT_W'(TA_CYC - 1);
              st  <= S_TURN;
            end else begin
              mem_dq_oe <= 1'b1;
              cnt       <= CNT_W'(SU_CYC - 1);
              st        <= S_WSETUP;
            end
          end
        end
        S_READ: if (cnt == '0) begin
          rd_data  <= mem_dq;
          rd_valid <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_ce   <= 1'b0;
          st       <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) begin
          mem_dq_oe <= 1'b1;
          cnt       <= CNT_W'(SU_CYC - 1);
          st        <= S_WSETUP;
        end else cnt <= cnt - 1'b1;
        S_WSETUP: if (cnt == '0) begin
          mem_we_n <= 1'b0;
          cnt      <= CNT_W'(WP_CYC - 1);
          st       <= S_WPULSE;
        end else cnt <= cnt - 1'b1;
        S_WPULSE: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          st       <= S_WHOLD;
        end else cnt <= cnt - 1'b1;
        S_WHOLD: begin
          mem_ce_n  <= 1'b1;
          mem_ce    <= 1'b0;
          mem_dq_oe <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_sram_ctrl_chk.sv
`timescale 1ns/1ps
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (!mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_addr) && !$past(mem_ce_n)));

  assert_hold_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && mem_dq_oe && !mem_ce_n && mem_ce));

  assert_no_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_drive_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/async_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_sram_ctrl_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int CLK_NS = 5;
  localparam int ACC_EXP = (10 + CLK_NS - 1) / CLK_NS;
  localparam int SU_EXP  = (1 + CLK_NS - 1) / CLK_NS;
  localparam int WP_EXP  = (7 + CLK_NS - 1) / CLK_NS;
  localparam int TA_EXP  = (5 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  always #2.5 clk = ~clk;

  async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_dq(mem_dq)
  );

  int total = 0, bad = 0, cyc = 0, last_acc = 0, fights = 0;
  bit done = 1'b0;
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_q [$];

  task automatic fail(input string req, input int act, input int exp);
    bad++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  always @(posedge clk) cyc++;

  // behavioural memory model
  logic [DW-1:0] mdl_mem [int];
  logic [DW-1:0] mdl_out = '0;
  logic [AW-1:0] rd_addr_q = '0, wr_addr_q = '0;
  logic prev_we_n = 1'b1, prev_rd = 1'b0;
  int we_low = 0, su_cnt = 0, rd_age = 0, rel = 0;
  wire rd_pins = !mem_ce_n && mem_ce && mem_we_n && !mem_oe_n;
  wire mdl_drive = rd_pins || (rel != 0);
  assign mem_dq = mdl_drive ? mdl_out : {DW{1'bz}};

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : '0;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe && mdl_drive) fights++;
    if (!mem_we_n) begin
      if (prev_we_n) begin
        total++;
        if (su_cnt < SU_EXP) fail("R3 setup", su_cnt, SU_EXP);
        wr_addr_q = mem_addr;
      end
      we_low++;
    end else if (!prev_we_n) begin
      total++;
      if (we_low != WP_EXP) fail("R7 pulse", we_low, WP_EXP);
      total++;
      if (!mem_dq_oe || mem_ce_n || !mem_ce || mem_addr != wr_addr_q)
        fail("R4 hold", int'(mem_addr), int'(wr_addr_q));
      mdl_mem[int'(mem_addr)] = mem_dq;
      we_low = 0;
    end
    if (mem_dq_oe && mem_we_n && !mem_ce_n) su_cnt++;
    else if (!mem_dq_oe) su_cnt = 0;
    prev_we_n = mem_we_n;
    if (rd_pins) begin
      rd_age = (prev_rd && mem_addr == rd_addr_q) ? rd_age + 1 : 1;
      rd_addr_q = mem_addr;
      mdl_out = (rd_age >= ACC_EXP) ? peek(mem_addr) : ~peek(mem_addr);
    end else begin
      if (prev_rd) rel = TA_EXP;
      else if (rel > 0) rel--;
      rd_age = 0;
    end
    prev_rd = rd_pins;
  end

  // monitor
  bit prev_rdv = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      total++;
      if (prev_rdv) fail("R2 strobe length", 2, 1);
      total++;
      if (cyc - last_acc != ACC_EXP) fail("R7 access wait", cyc - last_acc, ACC_EXP);
      total++;
      if (exp_q.size() == 0) fail("R8 unexpected data", int'(rd_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) fail("R8 read data", int'(rd_data), int'(e));
      end
    end
    prev_rdv = rd_valid;
  end

  // driver
  task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    total++;
    if (req_ready) fail("R6 ready after accept", 1, 0);
    if (we) shadow[int'(a)] = d;
    else begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : '0);
      last_acc = cyc;
    end
  endtask

  task automatic check_idle(input string tag);
    total++;
    if (!(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid))
      fail(tag, {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid}, 7'b1011010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    xfer(1'b1, 17'h00000, 8'h3C);
    xfer(1'b1, 17'h1FFFF, 8'hC3);
    xfer(1'b1, 17'h12345, 8'h55);
    xfer(1'b1, 17'h0AAAA, 8'hAA);
    xfer(1'b1, 17'h00001, 8'hFF);
    xfer(1'b0, 17'h00000, 8'h00);
    xfer(1'b0, 17'h1FFFF, 8'h00);
    xfer(1'b0, 17'h12345, 8'h00);
    xfer(1'b1, 17'h12345, 8'h00);   // R5: write right after read
    xfer(1'b0, 17'h12345, 8'h00);   // R8: overwritten word
    xfer(1'b1, 17'h00000, 8'h81);
    xfer(1'b0, 17'h0AAAA, 8'h00);
    xfer(1'b0, 17'h00001, 8'h00);
    xfer(1'b0, 17'h00000, 8'h00);
    for (int i = 0; i < 6; i++) begin
      xfer(1'b1, AW'(17'h10000 + i * 17'h0123), DW'(8'h11 * i + 8'h07));
      xfer(1'b0, AW'(17'h10000 + i * 17'h0123), 8'h00);
    end
    repeat (8) @(negedge clk);
    check_idle("R1 idle at end");
    total++;
    if (exp_q.size() != 0) fail("R2 missing read strobe", exp_q.size(), 0);
    total++;
    if (fights != 0) fail("R5 bus contention cycles", fights, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fail("watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule